// File: doc/BRIEF.md
# Hidden-Stack Destructive Operation Executor

This unit runs register operations that lose information (bitwise AND, bitwise OR, load of a constant, logical left shift) without losing anything. Before the destination register is overwritten, its old contents are moved into a temporary register. After the result has been written, that temporary value is pushed, together with the destination index, onto a private stack. No program operation can address this stack.

A forward operation takes three steps: move, compute and push. In unwind mode, each request removes the most recent record from the stack. It first lowers the stack pointer and then writes the saved value back into the register that was recorded. Issuing unwind requests repeatedly rolls the register file back, operation by operation, in the reverse of execution order, and releases the stack space. A combinational read port shows the program-visible register file. Two flags report when the stack is full and when it is empty.

Top module: `gs_exec`

## Requirements
- R1: After reset, busy and done are low, stk_empty is high, stk_full is low and every register reads zero on rd_data.
- R2: An accepted forward request (req_valid high, req_rev low, unit idle, stack not full) keeps busy high for exactly the three cycles that follow the accepting edge. After that, busy is low and done is high for one cycle.
- R3: The opcode req_op selects the result: 2'b00 gives dst AND src, 2'b01 gives dst OR src, 2'b10 loads req_imm, and 2'b11 shifts dst left by the low log2(W) bits of src, filling with zeros. The destination reads zero after the first step. The result appears after the second step. The src operand is read after the destination has been cleared, so src equal to dst gives a zero operand.
- R4: Each completed forward operation stores the old destination value and its index at the current stack pointer, then raises the pointer by one.
- R5: An accepted unwind request (req_rev high, stack not empty) first lowers the pointer, then restores the recorded register from the saved value. Busy is high for two cycles, followed by a one-cycle done pulse. Records are undone last-in first-out.
- R6: A forward request while the stack is full is refused. Busy and done stay low, no register changes and stk_full stays high.
- R7: An unwind request while the stack is empty is refused. Busy and done stay low, no register changes and stk_empty stays high.
- R8: Requests presented while busy is high are ignored and do not change the operation in progress.
- R9: stk_full is high exactly when DEPTH records are held, and stk_empty is high exactly when none are held.
- R10: rd_data shows the register selected by rd_sel combinationally. The stack contents never appear on any port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request strobe, sampled while idle |
| req_rev | input | 1 | 0 = forward operation, 1 = unwind one record |
| req_op | input | 2 | Forward opcode (see R3) |
| req_dst | input | log2(NREG) | Destination register index |
| req_src | input | log2(NREG) | Source register index |
| req_imm | input | W | Constant for the load opcode |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| stk_full | output | 1 | Hidden stack holds DEPTH records |
| stk_empty | output | 1 | Hidden stack holds no records |
| rd_sel | input | log2(NREG) | Register read select |
| rd_data | output | W | Selected register value |

## Verification
The bench builds the unit with W=8, NREG=4 and DEPTH=8. Eight forward operations therefore fill the stack, so both the full refusal and the empty refusal are reached many times in each random round. With only four registers, src often equals dst, and the zeroed-operand case shows up often. The 3-bit shift field covers every shift amount. A bench model keeps its own copy of the registers and the stack, and predicts every intermediate and restored value.

// File: rtl/gs_pkg.sv
`timescale 1ns/1ps
package gs_pkg;

  typedef enum logic [1:0] {
    OP_AND = 2'b00,
    OP_OR  = 2'b01,
    OP_LDI = 2'b10,
    OP_SLL = 2'b11
  } gs_op_e;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_MOVE = 3'd1,
    S_COMP = 3'd2,
    S_PUSH = 3'd3,
    S_DEC  = 3'd4,
    S_REST = 3'd5
  } gs_state_e;

endpackage

// File: rtl/gs_regfile.sv
`timescale 1ns/1ps
module gs_regfile #(
  parameter int W    = 16,
  parameter int NREG = 8,
  parameter int IW   = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [IW-1:0] ra_addr,
  output logic [W-1:0]  ra_data,
  input  logic [IW-1:0] rb_addr,
  output logic [W-1:0]  rb_data,
  input  logic [IW-1:0] rc_addr,
  output logic [W-1:0]  rc_data
);

  logic [W-1:0] regs_q [NREG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
    end else if (we) begin
      regs_q[waddr] <= wdata;
    end
  end

  assign ra_data = regs_q[ra_addr];
  assign rb_data = regs_q[rb_addr];
  assign rc_data = regs_q[rc_addr];

endmodule

// File: rtl/gs_alu.sv
`timescale 1ns/1ps
module gs_alu
  import gs_pkg::*;
#(
  parameter int W = 16
) (
  input  gs_op_e       op,
  input  logic [W-1:0] a_val,
  input  logic [W-1:0] b_val,
  input  logic [W-1:0] imm,
  output logic [W-1:0] res
);

  localparam int SW = (W > 1) ? $clog2(W) : 1;

  always_comb begin
    unique case (op)
      OP_AND:  res = a_val & b_val;
      OP_OR:   res = a_val | b_val;
      OP_LDI:  res = imm;
      OP_SLL:  res = a_val << b_val[SW-1:0];
      default: res = '0;
    endcase
  end

endmodule

// File: rtl/gs_stack.sv
`timescale 1ns/1ps
module gs_stack #(
  parameter int EW    = 19,
  parameter int DEPTH = 16,
  parameter int PW    = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [EW-1:0] wdata,
  input  logic          dec,
  output logic [EW-1:0] rdata,
  output logic [PW-1:0] sp,
  output logic          full,
  output logic          empty
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [EW-1:0] mem_q [DEPTH];
  logic [PW-1:0] sp_q;
  logic [PW-1:0] sp_d;
  logic          sp_en;

  always_comb begin
    sp_en = push | dec;
    sp_d  = sp_q;
    if (push)     sp_d = sp_q + 1'b1;
    else if (dec) sp_d = sp_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sp_q <= '0;
    else if (sp_en) sp_q <= sp_d;
  end

  always_ff @(posedge clk) begin
    if (push) mem_q[sp_q[AW-1:0]] <= wdata;
  end

  assign rdata = mem_q[sp_q[AW-1:0]];
  assign sp    = sp_q;
  assign full  = (sp_q == PW'(DEPTH));
  assign empty = (sp_q == '0);

endmodule

// File: rtl/gs_seq.sv
`timescale 1ns/1ps
module gs_seq
  import gs_pkg::*;
#(
  parameter int W  = 16,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_rev,
  input  logic [1:0]    req_op,
  input  logic [IW-1:0] req_dst,
  input  logic [IW-1:0] req_src,
  input  logic [W-1:0]  req_imm,
  input  logic          stk_full,
  input  logic          stk_empty,
  input  logic [W-1:0]  dst_val,
  input  logic [W-1:0]  alu_res,
  input  logic [IW-1:0] pop_idx,
  input  logic [W-1:0]  pop_val,
  output logic          busy,
  output logic          done,
  output logic          push,
  output logic          dec,
  output logic          rf_we,
  output logic [IW-1:0] rf_waddr,
  output logic [W-1:0]  rf_wdata,
  output gs_op_e        cur_op,
  output logic [IW-1:0] cur_dst,
  output logic [IW-1:0] cur_src,
  output logic [W-1:0]  cur_imm,
  output logic [W-1:0]  tmp
);

  gs_state_e state_q, state_d;
  logic      done_q, done_d;
  logic      acc_fwd, acc_rev, cap_en, tmp_en;

  always_comb begin
    acc_fwd = (state_q == S_IDLE) && req_valid && !req_rev && !stk_full;
    acc_rev = (state_q == S_IDLE) && req_valid &&  req_rev && !stk_empty;
    cap_en  = acc_fwd;
    tmp_en  = (state_q == S_MOVE);
    push    = (state_q == S_PUSH);
    dec     = (state_q == S_DEC);
    done_d  = (state_q == S_PUSH) || (state_q == S_REST);
    state_d = state_q;
    unique case (state_q)
      S_IDLE: begin
        if (acc_fwd)      state_d = S_MOVE;
        else if (acc_rev) state_d = S_DEC;
      end
      S_MOVE:  state_d = S_COMP;
      S_COMP:  state_d = S_PUSH;
      S_PUSH:  state_d = S_IDLE;
      S_DEC:   state_d = S_REST;
      S_REST:  state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_comb begin
    rf_we    = 1'b0;
    rf_waddr = cur_dst;
    rf_wdata = '0;
    unique case (state_q)
      S_MOVE: begin
        rf_we    = 1'b1;
        rf_wdata = '0;
      end
      S_COMP: begin
        rf_we    = 1'b1;
        rf_wdata = alu_res;
      end
      S_REST: begin
        rf_we    = 1'b1;
        rf_waddr = pop_idx;
        rf_wdata = pop_val;
      end
      default: rf_we = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      done_q  <= 1'b0;
      cur_op  <= OP_AND;
      cur_dst <= '0;
      cur_src <= '0;
      cur_imm <= '0;
      tmp     <= '0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      if (cap_en) begin
        cur_op  <= gs_op_e'(req_op);
        cur_dst <= req_dst;
        cur_src <= req_src;
        cur_imm <= req_imm;
      end
      if (tmp_en) tmp <= dst_val;
    end
  end

  assign busy = (state_q != S_IDLE);
  assign done = done_q;

endmodule

// File: rtl/gs_exec.sv
`timescale 1ns/1ps
module gs_exec
  import gs_pkg::*;
#(
  parameter  int W     = 16,
  parameter  int NREG  = 8,
  parameter  int DEPTH = 16,
  localparam int IW    = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_rev,
  input  logic [1:0]    req_op,
  input  logic [IW-1:0] req_dst,
  input  logic [IW-1:0] req_src,
  input  logic [W-1:0]  req_imm,
  output logic          busy,
  output logic          done,
  output logic          stk_full,
  output logic          stk_empty,
  input  logic [IW-1:0] rd_sel,
  output logic [W-1:0]  rd_data
);

  localparam int PW = $clog2(DEPTH + 1);
  localparam int EW = IW + W;

  logic          rst_meta, rst_n_q;
  logic          push_s, dec_s, rf_we;
  logic [IW-1:0] rf_waddr, cur_dst, cur_src, pop_idx;
  logic [W-1:0]  rf_wdata, cur_imm, tmp, dst_val, src_val, alu_res, pop_val;
  logic [EW-1:0] push_data, pop_data;
  logic [PW-1:0] sp_s;
  gs_op_e        cur_op;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {rst_n_q, rst_meta} <= 2'b00;
    else        {rst_n_q, rst_meta} <= {rst_meta, 1'b1};
  end

  gs_seq #(.W(W), .IW(IW)) u_seq (
    .clk(clk), .rst_n(rst_n_q),
    .req_valid(req_valid), .req_rev(req_rev), .req_op(req_op),
    .req_dst(req_dst), .req_src(req_src), .req_imm(req_imm),
    .stk_full(stk_full), .stk_empty(stk_empty),
    .dst_val(dst_val), .alu_res(alu_res),
    .pop_idx(pop_idx), .pop_val(pop_val),
    .busy(busy), .done(done), .push(push_s), .dec(dec_s),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
    .cur_op(cur_op), .cur_dst(cur_dst), .cur_src(cur_src),
    .cur_imm(cur_imm), .tmp(tmp)
  );

  gs_regfile #(.W(W), .NREG(NREG), .IW(IW)) u_rf (
    .clk(clk), .rst_n(rst_n_q),
    .we(rf_we), .waddr(rf_waddr), .wdata(rf_wdata),
    .ra_addr(cur_dst), .ra_data(dst_val),
    .rb_addr(cur_src), .rb_data(src_val),
    .rc_addr(rd_sel), .rc_data(rd_data)
  );

  gs_alu #(.W(W)) u_alu (
    .op(cur_op), .a_val(tmp), .b_val(src_val), .imm(cur_imm), .res(alu_res)
  );

  assign push_data = {cur_dst, tmp};
  assign pop_idx   = pop_data[EW-1:W];
  assign pop_val   = pop_data[W-1:0];

  gs_stack #(.EW(EW), .DEPTH(DEPTH), .PW(PW)) u_stk (
    .clk(clk), .rst_n(rst_n_q),
    .push(push_s), .wdata(push_data), .dec(dec_s),
    .rdata(pop_data), .sp(sp_s), .full(stk_full), .empty(stk_empty)
  );

endmodule

// File: rtl/gs_exec_chk.sv
`timescale 1ns/1ps
module gs_exec_chk #(
  parameter int DEPTH = 16,
  parameter int PW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_rev,
  input logic          busy,
  input logic          done,
  input logic          stk_full,
  input logic          stk_empty,
  input logic          push,
  input logic          dec,
  input logic [PW-1:0] sp
);

  p_fwd_timing_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_valid && !req_rev && !stk_full)
      |=> busy ##1 busy ##1 busy ##1 (!busy && done));

  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_push_inc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> (sp == PW'($past(sp) + 1'b1)));

  p_rev_timing_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_valid && req_rev && !stk_empty)
      |=> busy ##1 busy ##1 (!busy && done));

  p_pop_dec_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dec |=> (sp == PW'($past(sp) - 1'b1)));

  p_full_refuse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_valid && !req_rev && stk_full)
      |=> (!busy && !done && stk_full));

  p_empty_refuse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_valid && req_rev && stk_empty)
      |=> (!busy && !done && stk_empty));

  p_depth_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sp <= PW'(DEPTH));

endmodule

bind gs_exec gs_exec_chk #(.DEPTH(DEPTH), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n_q), .req_valid(req_valid), .req_rev(req_rev),
  .busy(busy), .done(done), .stk_full(stk_full), .stk_empty(stk_empty),
  .push(push_s), .dec(dec_s), .sp(sp_s)
);

// File: tb/gs_exec_tb.sv
`timescale 1ns/1ps
module gs_exec_tb;

  localparam int TW = 8;
  localparam int TN = 4;
  localparam int TD = 8;
  localparam int TI = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid, req_rev;
  logic [1:0]    req_op;
  logic [TI-1:0] req_dst, req_src, rd_sel;
  logic [TW-1:0] req_imm, rd_data;
  logic          busy, done, stk_full, stk_empty;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;

  logic [TW-1:0] m_reg [TN];
  logic [TW-1:0] m_val [TD];
  logic [TI-1:0] m_idx [TD];
  int            m_sp;

  always #2 clk = ~clk;

  gs_exec #(.W(TW), .NREG(TN), .DEPTH(TD)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_rev(req_rev),
    .req_op(req_op), .req_dst(req_dst), .req_src(req_src), .req_imm(req_imm),
    .busy(busy), .done(done), .stk_full(stk_full), .stk_empty(stk_empty),
    .rd_sel(rd_sel), .rd_data(rd_data)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [TW-1:0] f_res(input logic [1:0] op, input logic [TW-1:0] a,
                                          input logic [TW-1:0] b, input logic [TW-1:0] imm);
    case (op)
      2'b00:   return a & b;
      2'b01:   return a | b;
      2'b10:   return imm;
      default: return a << b[2:0];
    endcase
  endfunction

  task automatic chk_regs(input string tag);
    for (int i = 0; i < TN; i++) begin
      rd_sel = TI'(i);
      #0.1;
      chk(tag, {24'd0, rd_data}, {24'd0, m_reg[i]});
    end
  endtask

  task automatic junk_req();
    req_valid = 1'b1;
    req_rev   = 1'($urandom);
    req_op    = 2'($urandom);
    req_dst   = TI'($urandom);
    req_src   = TI'($urandom);
    req_imm   = TW'($urandom);
  endtask

  task automatic fwd(input logic [1:0] op, input logic [TI-1:0] dst,
                     input logic [TI-1:0] src, input logic [TW-1:0] imm);
    logic [TW-1:0] old_v, b_v, res_v;
    @(negedge clk);
    req_valid = 1'b1; req_rev = 1'b0; req_op = op;
    req_dst = dst; req_src = src; req_imm = imm;
    if (m_sp == TD) begin
      @(negedge clk);
      chk("R6 busy on refused push", {31'd0, busy}, 0);
      chk("R6 done on refused push", {31'd0, done}, 0);
      req_valid = 1'b0;
      chk("R6 full stays", {31'd0, stk_full}, 1);
      chk_regs("R6 regs unchanged");
      return;
    end
    old_v = m_reg[dst];
    b_v   = (src == dst) ? '0 : m_reg[src];
    res_v = f_res(op, old_v, b_v, imm);
    @(negedge clk);
    chk("R2 busy step1", {31'd0, busy}, 1);
    junk_req();  // R8: ignored while busy
    rd_sel = dst;
    @(negedge clk);
    chk("R2 busy step2", {31'd0, busy}, 1);
    #0.1;
    chk("R3 dst emptied by move", {24'd0, rd_data}, 0);
    @(negedge clk);
    chk("R2 busy step3", {31'd0, busy}, 1);
    #0.1;
    chk("R3 result", {24'd0, rd_data}, {24'd0, res_v});
    @(negedge clk);
    req_valid = 1'b0;
    chk("R2 busy low at end", {31'd0, busy}, 0);
    chk("R2 done pulse", {31'd0, done}, 1);
    m_idx[m_sp] = dst;
    m_val[m_sp] = old_v;
    m_sp++;
    m_reg[dst] = res_v;
    chk("R9 full flag", {31'd0, stk_full}, {31'd0, (m_sp == TD)});
    chk("R4 not empty after push", {31'd0, stk_empty}, 0);
    chk_regs("R8 R3 regs after op");
  endtask

  task automatic rev();
    @(negedge clk);
    req_valid = 1'b1; req_rev = 1'b1;
    if (m_sp == 0) begin
      @(negedge clk);
      chk("R7 busy on refused pop", {31'd0, busy}, 0);
      chk("R7 done on refused pop", {31'd0, done}, 0);
      req_valid = 1'b0;
      chk("R7 empty stays", {31'd0, stk_empty}, 1);
      chk_regs("R7 regs unchanged");
      return;
    end
    @(negedge clk);
    chk("R5 busy step1", {31'd0, busy}, 1);
    junk_req();  // R8: ignored while busy
    @(negedge clk);
    chk("R5 busy step2", {31'd0, busy}, 1);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R5 busy low at end", {31'd0, busy}, 0);
    chk("R5 done pulse", {31'd0, done}, 1);
    m_sp--;
    m_reg[m_idx[m_sp]] = m_val[m_sp];
    chk("R9 empty flag", {31'd0, stk_empty}, {31'd0, (m_sp == 0)});
    chk("R9 full low after pop", {31'd0, stk_full}, 0);
    chk_regs("R5 regs restored");
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; req_valid = 1'b0; req_rev = 1'b0; req_op = '0;
    req_dst = '0; req_src = '0; req_imm = '0; rd_sel = '0;
    m_sp = 0;
    for (int i = 0; i < TN; i++) m_reg[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 busy", {31'd0, busy}, 0);
    chk("R1 done", {31'd0, done}, 0);
    chk("R1 empty", {31'd0, stk_empty}, 1);
    chk("R1 full", {31'd0, stk_full}, 0);
    chk_regs("R1 R10 regs zero");

    // Directed: fill exactly to DEPTH
    fwd(2'b10, 2'd0, 2'd0, 8'hF0);
    fwd(2'b10, 2'd1, 2'd0, 8'h3C);
    fwd(2'b00, 2'd0, 2'd1, 8'h00);
    rd_sel = 2'd0; #0.1;
    chk("R3 AND F0&3C", {24'd0, rd_data}, 32'h30);
    fwd(2'b01, 2'd2, 2'd1, 8'h00);
    fwd(2'b10, 2'd3, 2'd0, 8'h05);
    fwd(2'b11, 2'd1, 2'd3, 8'h00);
    rd_sel = 2'd1; #0.1;
    chk("R3 SLL 3C by 5", {24'd0, rd_data}, 32'h80);
    fwd(2'b00, 2'd2, 2'd2, 8'h00);
    rd_sel = 2'd2; #0.1;
    chk("R3 AND src==dst gives zero", {24'd0, rd_data}, 32'h0);
    fwd(2'b10, 2'd0, 2'd0, 8'hAA);
    chk("R9 full at depth", {31'd0, stk_full}, 1);
    fwd(2'b10, 2'd1, 2'd0, 8'h55);   // R6 refused
    for (int k = 0; k < TD; k++) rev();
    chk_regs("R5 full unwind back to zero");
    rev();                            // R7 refused

    // Constrained random rounds
    for (int r = 0; r < 30; r++) begin
      int nf, nr;
      nf = $urandom_range(1, 10);
      nr = $urandom_range(1, 10);
      for (int k = 0; k < nf; k++)
        fwd(2'($urandom), TI'($urandom), TI'($urandom), TW'($urandom));
      for (int k = 0; k < nr; k++) rev();
    end
    while (m_sp > 0) rev();
    rev();
    chk_regs("R5 final unwind");

    summary();
  end

endmodule